// File: doc/BRIEF.md
# Encoded Output Post-Divider

This block divides a fast synthesizer clock down for one output path. A single 8-bit setting word holds a mode bit and a 7-bit count field. Together they select one of four behaviours: a fixed halving of the input, an even divide whose ratio follows the count field, a straight pass of the input clock, or a stopped output held low. Two status flags report the pass and stopped cases. Every divided output has a 50% duty cycle.

The setting can be rewritten at any time. A new word is adopted only at the instant the divided output would next rise, so a phase in progress is never cut short. When the path is stopped or passing the input through, a new word is adopted on the next input edge. The change between the divided clock and the raw input goes through a glitch-free selector. That selector only moves while both of its sources are low.

Top module: `vco_post_div`

## Requirements
- R1: With the mode bit (setting bit 7) at 0 and the count field (bits 6:0) not all ones, `clk_out` is `clk_in` divided by 2: high for one input cycle, then low for one.
- R2: With bit 7 at 1 and bits 6:0 holding a value Q below 127, `clk_out` is high for Q+2 input cycles, then low for Q+2.
- R3: Setting word 0x7F (mode 0, count all ones) stops the output: `clk_out` stays low and `st_off` is 1.
- R4: Setting word 0xFF (mode 1, count all ones) passes the input through: `clk_out` follows `clk_in`, `st_bypass` is 1 and `st_off` is 0.
- R5: The mode bit is bit 7 of `cfg_word` and the count field is bits 6:0. Example words: 0x80 gives half-period 2, 0xFE gives half-period 128, 0x7E gives divide by 2.
- R6: While the output is dividing, a new setting takes effect only at the next rising edge of `clk_out`. The high phase and the low phase in progress both finish with the old length.
- R7: While stopped or in pass mode, a new setting takes effect at the next rising edge of `clk_in`. The status flags reflect it after that edge.
- R8: During reset, `clk_out` is low, `st_off` is 1 and `st_bypass` is 0.
- R9: Moving into or out of pass mode produces no high or low pulse on `clk_out` shorter than half an input period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 8 | Setting: bit 7 mode, bits 6:0 count field |
| clk_out | output | 1 | Divided, passed or stopped clock |
| st_bypass | output | 1 | High while the adopted setting is pass mode |
| st_off | output | 1 | High while the adopted setting is stopped |

## Verification
The bench builds the block with its default 7-bit count field. This keeps the longest half-period at 128 input cycles, so random count values across the whole field, including both ends, fit in a short run. Directed words reach the all-ones encodings and the 0/126 limits. A mid-phase rewrite of the setting shows that adoption waits for the next rising boundary. Fine sub-cycle sampling across pass-mode transitions looks for runt pulses.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/100ps
package clkdiv_pkg;
    localparam int QW     = 7;
    localparam int CFG_W  = QW + 1;
    localparam int HALF_W = QW + 1;

    typedef enum logic [1:0] {
        MODE_DIV2 = 2'd0,
        MODE_EVEN = 2'd1,
        MODE_PASS = 2'd2,
        MODE_OFF  = 2'd3
    } div_mode_e;

    typedef struct packed {
        div_mode_e           mode;
        logic [HALF_W-1:0]   half;
    } div_set_t;

    function automatic div_set_t decode_cfg(input logic pm, input logic [QW-1:0] q);
        div_set_t s;
        if (&q) begin
            s.mode = pm ? MODE_PASS : MODE_OFF;
            s.half = '0;
        end else if (pm) begin
            s.mode = MODE_EVEN;
            s.half = HALF_W'(q) + HALF_W'(2);
        end else begin
            s.mode = MODE_DIV2;
            s.half = HALF_W'(1);
        end
        return s;
    endfunction

    function automatic logic is_running(input div_mode_e m);
        return (m == MODE_DIV2) || (m == MODE_EVEN);
    endfunction
endpackage

// File: rtl/pdiv_setting.sv
`timescale 1ns/100ps
module pdiv_setting
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             ld,
    output div_set_t         active,
    output div_set_t         pending
);
    assign pending = decode_cfg(cfg_word[QW], cfg_word[QW-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            active.mode <= MODE_OFF;
            active.half <= '0;
        end else if (ld) begin
            active <= pending;
        end
    end

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(active)); // R6
endmodule

// File: rtl/pdiv_toggle.sv
`timescale 1ns/100ps
module pdiv_toggle
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic              run,
    input  logic              next_run,
    input  logic [HALF_W-1:0] half,
    output logic              div_q,
    output logic              rise_due
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    logic [HALF_W-1:0] cnt;
    logic              at_end;

    assign at_end   = run && (cnt == half - ONE);
    assign rise_due = at_end && !div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (ld) begin
            cnt   <= '0;
            div_q <= run && next_run;
        end else if (at_end) begin
            cnt   <= '0;
            div_q <= ~div_q;
        end else if (run) begin
            cnt   <= cnt + ONE;
        end else begin
            cnt   <= '0;
            div_q <= 1'b0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half)); // R2
    AST_DIV_STEADY: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(div_q)); // R1
endmodule

// File: rtl/pdiv_clksel.sv
`timescale 1ns/100ps
module pdiv_clksel (
    input  logic clk_in,
    input  logic rst,
    input  logic div_clk,
    input  logic want_pass,
    output logic clk_out
);
    logic pass_sel;

    always_ff @(negedge clk_in) begin
        if (rst) begin
            pass_sel <= 1'b0;
        end else if (!div_clk) begin
            pass_sel <= want_pass;
        end
    end

    always_comb begin
        clk_out = pass_sel ? clk_in : div_clk;
    end

    AST_SEL_SAFE: assert property (@(negedge clk_in) disable iff (rst)
        div_clk |=> $stable(pass_sel)); // R9
endmodule

// File: rtl/vco_post_div.sv
`timescale 1ns/100ps
module vco_post_div
    import clkdiv_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             clk_out,
    output logic             st_bypass,
    output logic             st_off
);
    div_set_t act_set;
    div_set_t nxt_set;
    logic     run_now;
    logic     run_next;
    logic     rise_due;
    logic     ld;
    logic     div_clk;

    assign run_now  = is_running(act_set.mode);
    assign run_next = is_running(nxt_set.mode);
    assign ld       = !run_now || rise_due;

    pdiv_setting i_setting (
        .clk      (clk_in),
        .rst      (rst),
        .cfg_word (cfg_word),
        .ld       (ld),
        .active   (act_set),
        .pending  (nxt_set)
    );

    pdiv_toggle i_toggle (
        .clk      (clk_in),
        .rst      (rst),
        .ld       (ld),
        .run      (run_now),
        .next_run (run_next),
        .half     (act_set.half),
        .div_q    (div_clk),
        .rise_due (rise_due)
    );

    pdiv_clksel i_clksel (
        .clk_in    (clk_in),
        .rst       (rst),
        .div_clk   (div_clk),
        .want_pass (act_set.mode == MODE_PASS),
        .clk_out   (clk_out)
    );

    assign st_bypass = (act_set.mode == MODE_PASS);
    assign st_off    = (act_set.mode == MODE_OFF);

    AST_OFF_LOW: assert property (@(posedge clk_in) disable iff (rst)
        st_off |-> !div_clk); // R3
    AST_PASS_QUIET: assert property (@(posedge clk_in) disable iff (rst)
        st_bypass |-> !div_clk); // R4
    AST_FLAGS_EXCL: assert property (@(posedge clk_in) disable iff (rst)
        $onehot0({st_bypass, st_off})); // R4
endmodule

// File: tb/test_vco_post_div.sv
`timescale 1ns/100ps
module test_vco_post_div;
    logic       clk_in = 1'b0;
    logic       rst;
    logic [7:0] cfg_word;
    logic       clk_out;
    logic       st_bypass;
    logic       st_off;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk_in = ~clk_in;

    vco_post_div i_vco_post_div (
        .clk_in    (clk_in),
        .rst       (rst),
        .cfg_word  (cfg_word),
        .clk_out   (clk_out),
        .st_bypass (st_bypass),
        .st_off    (st_off)
    );

    function automatic int exp_half(input logic [7:0] w);
        return w[7] ? int'(w[6:0]) + 2 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(output logic v);
        @(negedge clk_in);
        #1;
        v = clk_out;
    endtask

    task automatic measure(output int hi, output int lo);
        logic v;
        int guard = 0;
        hi = 0;
        lo = 0;
        step(v);
        while (v !== 1'b0 && guard < 1000) begin step(v); guard++; end
        while (v !== 1'b1 && guard < 2000) begin step(v); guard++; end
        while (v === 1'b1 && guard < 3000) begin hi++; step(v); guard++; end
        while (v === 1'b0 && guard < 4000) begin lo++; step(v); guard++; end
    endtask

    task automatic run_cfg(input logic [7:0] w, input string tag);
        int hi, lo, ones;
        logic v;
        @(negedge clk_in);
        #1;
        cfg_word = w;
        repeat (700) @(negedge clk_in);
        #1;
        if (w == 8'h7F) begin
            ones = 0;
            for (int i = 0; i < 600; i++) begin step(v); if (v !== 1'b0) ones++; end
            check(ones == 0, {tag, " R3 low"}, ones, 0);
            check(st_off === 1'b1, {tag, " R3 st_off"}, st_off, 1);
        end else if (w == 8'hFF) begin
            ones = 0;
            for (int i = 0; i < 20; i++) begin
                @(posedge clk_in); #1; if (clk_out === 1'b1) ones++;
                @(negedge clk_in); #1; if (clk_out === 1'b0) ones++;
            end
            check(ones == 40, {tag, " R4 follow"}, ones, 40);
            check(st_bypass === 1'b1 && st_off === 1'b0, {tag, " R4 flags"},
                  {st_bypass, st_off}, 2);
        end else begin
            measure(hi, lo);
            check(hi == exp_half(w) && lo == exp_half(w),
                  {tag, w[7] ? " R2 ratio" : " R1 ratio"}, hi * 1000 + lo,
                  exp_half(w) * 1001);
            check(st_bypass === 1'b0 && st_off === 1'b0, {tag, " flags"},
                  {st_bypass, st_off}, 0);
        end
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int hi, lo, run_len, min_hi, min_lo;
        logic v, prev;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1;
        cfg_word = 8'h7F;
        repeat (5) @(negedge clk_in);
        #1;
        check(clk_out === 1'b0 && st_off === 1'b1 && st_bypass === 1'b0, "R8 reset",
              {clk_out, st_off, st_bypass}, 3'b010);
        cfg_word = 8'h00;
        rst = 1'b0;
        @(negedge clk_in);
        #1;
        check(st_off === 1'b0, "R7 leave off", st_off, 0);

        run_cfg(8'h80, "R5 0x80");
        run_cfg(8'hFE, "R5 0xFE");
        run_cfg(8'h7E, "R5 0x7E");
        run_cfg(8'h7F, "off");
        run_cfg(8'h83, "even3");
        run_cfg(8'hFF, "pass");

        // R7: leave pass mode, flag drops after one clk_in rising edge
        @(negedge clk_in); #1;
        cfg_word = 8'h81;
        @(negedge clk_in); #1;
        check(st_bypass === 1'b0, "R7 leave pass", st_bypass, 0);

        // R6: rewrite during a long high phase
        cfg_word = 8'h88;
        repeat (700) @(negedge clk_in);
        step(v);
        while (v !== 1'b0) step(v);
        while (v !== 1'b1) step(v);
        hi = 0;
        while (v === 1'b1) begin
            hi++;
            if (hi == 4) cfg_word = 8'h00;
            step(v);
        end
        lo = 0;
        while (v === 1'b0 && lo < 100) begin lo++; step(v); end
        check(hi == 10, "R6 high kept", hi, 10);
        check(lo == 10, "R6 low kept", lo, 10);
        measure(hi, lo);
        check(hi == 1 && lo == 1, "R6 new ratio", hi * 1000 + lo, 1001);

        // R9: fine sampling across pass-mode transitions
        cfg_word = 8'h82;
        repeat (100) @(negedge clk_in);
        #0.5;
        cfg_word = 8'hFF;
        prev = clk_out;
        run_len = 0;
        min_hi = 1000;
        min_lo = 1000;
        for (int k = 0; k < 800; k++) begin
            if (k == 400) cfg_word = 8'h82;
            #1;
            v = clk_out;
            if (v === prev) run_len++;
            else begin
                if (k > 2) begin
                    if (prev === 1'b1 && run_len < min_hi) min_hi = run_len;
                    if (prev === 1'b0 && run_len < min_lo) min_lo = run_len;
                end
                run_len = 1;
                prev = v;
            end
        end
        check(min_hi >= 2, "R9 high pulse", min_hi, 2);
        check(min_lo >= 2, "R9 low pulse", min_lo, 2);

        for (int i = 0; i < 30; i++) begin
            logic [7:0] w;
            w = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 126))};
            if (i % 10 == 9) w = (i % 20 == 9) ? 8'hFF : 8'h7F;
            run_cfg(w, "rand");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule